// File: doc/BRIEF.md
# Signature-Checked Retest Sequencer

This controller sits on the tester side of a multi-level test channel and decides what happens to a device once a test pass has been applied over that channel. When it is started it launches one complete test pass and waits for the pattern source to report that the pass is over. It then compares the signature read back from the device, which is a compaction of every pattern the device actually decoded, with the signature the patterns should have produced. A match means the channel carried the data correctly and the device is accepted for multi-level testing.

A mismatch is treated as a transmission error and not as a device defect, so the controller launches the entire test again. The number of repeats is bounded by a 4-bit limit that is taken at start. Once every allowed attempt has failed, the controller gives up on the multi-level channel and asks for the device to be tested over the plain binary channel. A device whose converter calibration already failed goes to the binary path at once and is never given a multi-level attempt. Both verdicts hold until the next start.

Top module: `sig_retest_seq`

## Requirements
- R1: While reset is asserted and until the first start, `pass_start_o`, `dev_ok_o` and `bin_fallback_o` are all 0.
- R2: A start accepted while `cal_fail_i` is 1 sets `bin_fallback_o` in the cycle after the start, and no `pass_start_o` pulse is issued.
- R3: A start accepted while `cal_fail_i` is 0 produces a `pass_start_o` pulse exactly one cycle wide, in the cycle after the start.
- R4: When `pass_done_i` is sampled during a pass and `sig_rd_i` equals `sig_exp_i`, `dev_ok_o` rises two cycles after that sample, on the first attempt or on any later attempt.
- R5: When `pass_done_i` is sampled with unequal signatures and attempts remain, a new `pass_start_o` pulse appears three cycles after that sample, and neither verdict output is raised.
- R6: With a limit L on `retry_lim_i`, at most L+1 passes are launched; when all of them mismatch, `bin_fallback_o` rises two cycles after the last `pass_done_i`. L = 0 allows exactly one pass.
- R7: The limit is captured when a start is accepted; changing `retry_lim_i` during the test has no effect on the number of passes.
- R8: `dev_ok_o` and `bin_fallback_o` hold until the next start; a new start clears them and restarts the attempt count from zero.
- R9: `start_i` raised while a test is in progress is ignored: no extra pass is launched and the test runs on unchanged.
- R10: `pass_done_i` outside a running pass (idle, or with a verdict held) is ignored: no output changes.
- R11: `dev_ok_o` and `bin_fallback_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin qualification of a new device |
| cal_fail_i | input | 1 | Converter calibration of the device failed; sampled with start |
| pass_done_i | input | 1 | The current test pass has finished |
| sig_rd_i | input | SIG_W | Signature read back from the device, valid with `pass_done_i` |
| sig_exp_i | input | SIG_W | Expected signature, valid with `pass_done_i` |
| retry_lim_i | input | LIM_W (4) | Maximum number of repeats after the first pass |
| pass_start_o | output | 1 | One-cycle request to launch a full test pass |
| dev_ok_o | output | 1 | Device qualified for multi-level testing (held) |
| bin_fallback_o | output | 1 | Device must be tested over the binary channel (held) |

## Verification
The bench walks the attempt boundary: limits of 0 and 2 with every pass mismatching, where an off-by-one counter would launch one pass too many or too few, and a mismatch followed by a match, where a design that treated the first failure as final would flag fallback. It changes the limit mid-test, which a design reading the live input would follow, and it raises start and pass-done in the wrong states, which a loosely decoded controller would turn into an extra pass or a flipped verdict. It also restarts from a fallback verdict to catch an attempt counter that is not cleared.

// File: rtl/rtseq_pkg.sv
package rtseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUN      = 3'd1,
    ST_CHECK    = 3'd2,
    ST_RETRY    = 3'd3,
    ST_PASS     = 3'd4,
    ST_FALLBACK = 3'd5
  } seq_state_e;

  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/rtseq_rst_sync.sv
module rtseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/rtseq_sig_cmp.sv
module rtseq_sig_cmp #(
  parameter int unsigned SIG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [SIG_W-1:0] sig_rd_i,
  input  logic [SIG_W-1:0] sig_exp_i,
  output logic             match_o
);
  logic match_q;
  logic match_d;

  always_comb begin
    match_d = match_q;
    if (capture_i) match_d = (sig_rd_i == sig_exp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match_o = match_q;
endmodule

// File: rtl/rtseq_attempt_ctr.sv
module rtseq_attempt_ctr #(
  parameter int unsigned LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             incr_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             exhausted_o
);
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic             cnt_en;
  logic             lim_en;

  always_comb begin
    lim_en = clear_i;
    lim_d  = lim_i;
    cnt_en = clear_i | incr_i;
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lim_en) lim_q <= lim_d;
    end
  end

  assign exhausted_o = (cnt_q >= lim_q);

  p_cnt_within_lim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));

  p_lim_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> $stable(lim_q));
endmodule

// File: rtl/rtseq_fsm.sv
module rtseq_fsm
  import rtseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cal_fail_i,
  input  logic pass_done_i,
  input  logic match_i,
  input  logic exhausted_i,
  output logic capture_o,
  output logic clear_o,
  output logic incr_o,
  output logic pass_start_o,
  output logic dev_ok_o,
  output logic fallback_o
);
  seq_state_e state_q, state_d;
  logic       launch_q, launch_d;
  logic       accept;

  always_comb begin
    accept = start_i &&
             (state_q == ST_IDLE || state_q == ST_PASS || state_q == ST_FALLBACK);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_PASS, ST_FALLBACK: begin
        if (accept) state_d = cal_fail_i ? ST_FALLBACK : ST_RUN;
      end
      ST_RUN: begin
        if (pass_done_i) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (match_i)          state_d = ST_PASS;
        else if (exhausted_i) state_d = ST_FALLBACK;
        else                  state_d = ST_RETRY;
      end
      ST_RETRY: state_d = ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb launch_d = (state_d == ST_RUN) && (state_q != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      launch_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      launch_q <= launch_d;
    end
  end

  assign capture_o    = (state_q == ST_RUN) && pass_done_i;
  assign clear_o      = accept;
  assign incr_o       = (state_q == ST_RETRY);
  assign pass_start_o = launch_q;
  assign dev_ok_o     = (state_q == ST_PASS);
  assign fallback_o   = (state_q == ST_FALLBACK);

  p_verdict_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_ok_o && fallback_o));

  p_launch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start_o |=> !pass_start_o);

  p_cal_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cal_fail_i) |=> (fallback_o && !pass_start_o));

  p_pass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ok_o && !start_i) |=> dev_ok_o);

  p_fallback_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback_o && !start_i) |=> fallback_o);

  p_no_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !pass_done_i) |=> !pass_start_o);

  p_exhaust_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !match_i && exhausted_i) |=> fallback_o);

  p_match_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && match_i) |=> dev_ok_o);
endmodule

// File: rtl/sig_retest_seq.sv
module sig_retest_seq
  import rtseq_pkg::*;
#(
  parameter int unsigned SIG_W = 16,
  parameter int unsigned LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cal_fail_i,
  input  logic             pass_done_i,
  input  logic [SIG_W-1:0] sig_rd_i,
  input  logic [SIG_W-1:0] sig_exp_i,
  input  logic [LIM_W-1:0] retry_lim_i,
  output logic             pass_start_o,
  output logic             dev_ok_o,
  output logic             bin_fallback_o
);
  logic srst_n;
  logic capture, clear, incr, match, exhausted;

  rtseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rtseq_sig_cmp #(.SIG_W(SIG_W)) u_cmp (
    .clk       (clk),
    .rst_n     (srst_n),
    .capture_i (capture),
    .sig_rd_i  (sig_rd_i),
    .sig_exp_i (sig_exp_i),
    .match_o   (match)
  );

  rtseq_attempt_ctr #(.LIM_W(LIM_W)) u_ctr (
    .clk         (clk),
    .rst_n       (srst_n),
    .clear_i     (clear),
    .incr_i      (incr),
    .lim_i       (retry_lim_i),
    .exhausted_o (exhausted)
  );

  rtseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (srst_n),
    .start_i      (start_i),
    .cal_fail_i   (cal_fail_i),
    .pass_done_i  (pass_done_i),
    .match_i      (match),
    .exhausted_i  (exhausted),
    .capture_o    (capture),
    .clear_o      (clear),
    .incr_o       (incr),
    .pass_start_o (pass_start_o),
    .dev_ok_o     (dev_ok_o),
    .fallback_o   (bin_fallback_o)
  );
endmodule

// File: tb/sim_sig_retest_seq.sv
module sim_sig_retest_seq;
  localparam int SIG_W = 16;
  localparam int LIM_W = 4;
  localparam logic [SIG_W-1:0] EXP_SIG = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cal_fail = 1'b0, pass_done = 1'b0;
  logic [SIG_W-1:0] sig_rd = '0;
  logic [LIM_W-1:0] lim = '0;
  logic pass_start, dev_ok, fallback;

  int n_chk = 0, n_bad = 0, n_starts = 0;

  always #10 clk = ~clk;

  sig_retest_seq #(.SIG_W(SIG_W), .LIM_W(LIM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cal_fail_i(cal_fail),
    .pass_done_i(pass_done), .sig_rd_i(sig_rd), .sig_exp_i(EXP_SIG),
    .retry_lim_i(lim), .pass_start_o(pass_start), .dev_ok_o(dev_ok),
    .bin_fallback_o(fallback)
  );

  always @(posedge clk) begin
    #2;
    if (pass_start) n_starts++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input bit cal, input int l);
    lim = l[LIM_W-1:0]; cal_fail = cal; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cal_fail = 1'b0;
  endtask

  task automatic do_done(input bit good);
    sig_rd = good ? EXP_SIG : (EXP_SIG ^ 16'h0100);
    pass_done = 1'b1;
    @(negedge clk);
    pass_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int n0;
    chk("R1", "pass_start in reset", pass_start, 0);
    chk("R1", "dev_ok in reset", dev_ok, 0);
    chk("R1", "fallback in reset", fallback, 0);
    cyc(2); rst_n = 1'b1; cyc(4);
    n0 = n_starts;
    pass_done = 1'b1; cyc(1); pass_done = 1'b0; cyc(3);
    chk("R10", "idle pass_done launches", n_starts - n0, 0);
    chk("R1", "dev_ok idle", dev_ok, 0);
    chk("R1", "fallback idle", fallback, 0);
  endtask

  task automatic t_cal_fail();
    int n0 = n_starts;
    do_start(1'b1, 3);
    chk("R2", "fallback after cal fail", fallback, 1);
    chk("R2", "pass_start after cal fail", pass_start, 0);
    cyc(3);
    chk("R2", "passes launched", n_starts - n0, 0);
    chk("R8", "fallback held", fallback, 1);
    n0 = n_starts;
    pass_done = 1'b1; sig_rd = EXP_SIG; cyc(1); pass_done = 1'b0; cyc(3);
    chk("R10", "fallback after stray done", fallback, 1);
    chk("R10", "launch after stray done", n_starts - n0, 0);
  endtask

  task automatic t_first_pass();
    do_start(1'b0, 3);
    chk("R3", "pass_start after start", pass_start, 1);
    chk("R8", "fallback cleared by start", fallback, 0);
    cyc(1);
    chk("R3", "pass_start width", pass_start, 0);
    cyc(4);
    sig_rd = EXP_SIG; pass_done = 1'b1; cyc(1); pass_done = 1'b0;
    chk("R4", "dev_ok one cycle after done", dev_ok, 0);
    cyc(1);
    chk("R4", "dev_ok two cycles after done", dev_ok, 1);
    cyc(5);
    chk("R8", "dev_ok held", dev_ok, 1);
    chk("R11", "fallback with dev_ok", fallback, 0);
  endtask

  task automatic t_stray_done_pass();
    int n0 = n_starts;
    sig_rd = EXP_SIG ^ 16'h0001; pass_done = 1'b1; cyc(1); pass_done = 1'b0; cyc(3);
    chk("R10", "dev_ok after stray bad done", dev_ok, 1);
    chk("R10", "launch after stray done", n_starts - n0, 0);
  endtask

  task automatic t_retry_then_pass();
    int n0 = n_starts;
    do_start(1'b0, 3);
    chk("R8", "dev_ok cleared by start", dev_ok, 0);
    cyc(2);
    do_done(1'b0);
    chk("R5", "dev_ok after mismatch", dev_ok, 0);
    chk("R5", "fallback after mismatch", fallback, 0);
    cyc(1);
    chk("R5", "relaunch three cycles after done", pass_start, 1);
    cyc(2);
    do_done(1'b1);
    chk("R4", "dev_ok on second attempt", dev_ok, 1);
    chk("R5", "passes launched", n_starts - n0, 2);
  endtask

  task automatic t_exhaust(input int l, input int l_after, input string req);
    int n0 = n_starts;
    do_start(1'b0, l);
    lim = l_after[LIM_W-1:0];
    for (int a = 0; a <= l; a++) begin
      cyc(2);
      do_done(1'b0);
      if (a < l) begin
        chk(req, "fallback before last attempt", fallback, 0);
        cyc(1);
      end else begin
        chk(req, "fallback after last attempt", fallback, 1);
      end
    end
    cyc(4);
    chk(req, "passes launched", n_starts - n0, l + 1);
    chk("R11", "dev_ok with fallback", dev_ok, 0);
  endtask

  task automatic t_busy_start();
    int n0;
    do_start(1'b0, 2);
    cyc(2);
    n0 = n_starts;
    start = 1'b1; cyc(1); start = 1'b0; cyc(2);
    chk("R9", "launch from busy start", n_starts - n0, 0);
    chk("R9", "dev_ok during pass", dev_ok, 0);
    chk("R9", "fallback during pass", fallback, 0);
    do_done(1'b1);
    chk("R9", "test completes normally", dev_ok, 1);
  endtask

  initial begin
    t_reset();
    t_cal_fail();
    t_first_pass();
    t_stray_done_pass();
    t_retry_then_pass();
    t_exhaust(2, 2, "R6");
    t_exhaust(0, 0, "R6");
    t_exhaust(1, 9, "R7");
    t_exhaust(1, 1, "R8");
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule